// File: doc/BRIEF.md
# Byte-serial command register controller

This block is the host-facing control front end of a keypad and general-purpose I/O controller. It is attached behind a byte-stream slave port of the I2C kind. The bit-level bus logic stays outside and hands the block three strobes: a transaction start, a received byte and a request for a byte to send. In a write transaction the first byte selects a command, and the following bytes are that command's parameters, numbered from zero. A read transaction returns response bytes for the command code most recently latched. Multi-byte responses come least significant byte first.

The block holds the settings used by the keypad scanner and the I/O pins. These are a configuration byte, an active time, a debounce time, the keypad dimensions, a clock setting and three 16-bit pin registers (pull select, direction, output state). Every parameter is checked as it arrives. Faults are gathered in a sticky error byte and reported through an interrupt status byte. The active-low interrupt line is held asserted while any status bit is set. When a command has used all of its parameters, the command register is parked on a lockout code, so that stray trailing bytes are flagged. Software must write the configuration once after power-up to leave the not-initialised state.

Top module: `kpc_cmd_ctrl`

## Requirements
- R1: After reset the configuration is 0x80, active time 125, debounce 3, keypad size 0x33, clock 0x08, the pin registers and error byte are 0, and the status byte holds only bit 4 (not initialised).
- R2: `irq_n` is low exactly when the status byte is nonzero.
- R3: A transaction start clears the byte index. In a write transaction, byte 0 becomes the command code. Later bytes are parameters 0, 1, 2, and so on. A command byte alone raises no error.
- R4: Once a command has consumed its parameters, the command code becomes 0xFF. A further parameter byte sets error bit 0 (bad parameter) and changes no setting.
- R5: A write parameter or a read addressed to an unknown command code sets error bit 1. Error bits accumulate by OR until hardware reset. Any new error sets status bit 3.
- R6: Command 0x83 with parameter 0xAA restores the R1 values of configuration, timing, size, clock and status. It leaves the error byte and pin registers alone. Any other parameter sets error bit 0 and changes nothing.
- R7: Reading status (0x82) returns the status byte as response byte 0 and then clears it, unless status bit 4 is set.
- R8: A keypad-size write (0x90) is stored. It is a bad parameter unless its low nibble is 3..12 and its high nibble is 3..8.
- R9: A debounce write (0x8F) of 0 is a bad parameter. A clock write (0x93) whose bits [1:0] are 01 or 10 is a bad parameter. In both cases the value is still stored.
- R10: Commands 0x84 (pull), 0x85 (direction) and 0x86 (state) take the low byte first, which clears the high byte, and then the high byte, which completes the command. Direction and state read back through 0x87 and 0x88 low byte first; later bytes read 0.
- R11: Reads return these values: 0x80 gives 0x00 then 0x04 then 0x00; 0x8C gives the error byte; 0x91 gives the keypad size; 0x92 gives the configuration low nibble; 0x94 gives (clock AND 0xFC) OR 0x02. A read response appears on `rd_data` with `rd_valid` one cycle after `rd_req`.
- R12: A configuration write (0x81) stores the byte, clears the status byte and pulses `fifo_clr` high for one cycle.
- R13: A `key_evt` pulse sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txn_start | input | 1 | Start of a bus transaction |
| wr_valid | input | 1 | Received byte strobe |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next response byte |
| rd_data | output | 8 | Response byte |
| rd_valid | output | 1 | Response byte is valid this cycle |
| key_evt | input | 1 | Keypad event from the scanner |
| irq_n | output | 1 | Active-low interrupt |
| fifo_clr | output | 1 | One-cycle flush pulse for the key FIFO |
| cfg_q | output | 8 | Configuration byte |
| act_time | output | 8 | Active time setting |
| dbnc_time | output | 8 | Debounce setting |
| kp_size | output | 8 | Keypad size (high nibble rows, low nibble columns) |
| clk_cfg | output | 8 | Clock setting |
| gpio_pull | output | 16 | Pull-select register |
| gpio_dir | output | 16 | Direction register |
| gpio_state | output | 16 | Output state register |

## Verification
The bench builds the block with its default parameters: a three-bit byte index and keypad limits of 3..12 columns and 3..8 rows. With these limits, both edges of each nibble range (2, 3, 12 and 13 low; 2, 3, 8 and 9 high) are single directed writes. The three-bit index also lets a short read burst go past the two meaningful ID bytes and show the zero fill. Each scenario starts from a hardware reset followed by a configuration write, so the sticky error bits of one scenario cannot hide a fault in the next.

// File: rtl/kpc_pkg.sv
package kpc_pkg;

  // Command codes seen on the byte stream
  localparam logic [7:0] OP_ID_RD     = 8'h80;
  localparam logic [7:0] OP_CFG_WR    = 8'h81;
  localparam logic [7:0] OP_STAT_RD   = 8'h82;
  localparam logic [7:0] OP_SOFT_RST  = 8'h83;
  localparam logic [7:0] OP_PULL_WR   = 8'h84;
  localparam logic [7:0] OP_DIR_WR    = 8'h85;
  localparam logic [7:0] OP_STATE_WR  = 8'h86;
  localparam logic [7:0] OP_DIR_RD    = 8'h87;
  localparam logic [7:0] OP_STATE_RD  = 8'h88;
  localparam logic [7:0] OP_FIFO_POP  = 8'h89;
  localparam logic [7:0] OP_FIFO_PEEK = 8'h8A;
  localparam logic [7:0] OP_ACT_WR    = 8'h8B;
  localparam logic [7:0] OP_ERR_RD    = 8'h8C;
  localparam logic [7:0] OP_ROT_RD    = 8'h8E;
  localparam logic [7:0] OP_DBNC_WR   = 8'h8F;
  localparam logic [7:0] OP_SIZE_WR   = 8'h90;
  localparam logic [7:0] OP_SIZE_RD   = 8'h91;
  localparam logic [7:0] OP_CFG_RD    = 8'h92;
  localparam logic [7:0] OP_CLK_WR    = 8'h93;
  localparam logic [7:0] OP_CLK_RD    = 8'h94;
  localparam logic [7:0] OP_LOCKOUT   = 8'hFF;

  localparam logic [7:0]  SOFT_RST_KEY = 8'hAA;
  localparam logic [15:0] ID_WORD      = 16'h0400;

  // Status and error bit positions
  localparam int ST_KEY    = 0;
  localparam int ST_ERR    = 3;
  localparam int ST_NOINIT = 4;
  localparam int ER_BADPAR = 0;
  localparam int ER_UNKCMD = 1;

  // Pin registers: index follows command code bits [1:0]
  localparam int GPIO_W    = 16;
  localparam int GPIO_REGS = 3;
  localparam int GPIO_PULL = 0;
  localparam int GPIO_DIR  = 1;
  localparam int GPIO_ST   = 2;

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] act;
    logic [7:0] dbnc;
    logic [7:0] size;
    logic [7:0] clkc;
  } ctl_regs_t;

  localparam ctl_regs_t CTL_RST = '{cfg: 8'h80, act: 8'd125, dbnc: 8'd3,
                                    size: 8'h33, clkc: 8'h08};
  localparam logic [7:0] STATUS_RST = 8'h10;

  // Actions decoded from one parameter byte
  typedef struct packed {
    logic                 cfg_we;
    logic                 act_we;
    logic                 dbnc_we;
    logic                 size_we;
    logic                 clk_we;
    logic [GPIO_REGS-1:0] gpio_lo_we;
    logic [GPIO_REGS-1:0] gpio_hi_we;
    logic                 done;
    logic                 bad_par;
    logic                 unk_cmd;
    logic                 soft_rst;
    logic                 cfg_clr;
  } wr_act_t;

endpackage

// File: rtl/kpc_byte_idx.sv
module kpc_byte_idx #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_n;
  logic             idx_en;

  always_comb begin
    idx_n = idx;
    if (clr) begin
      idx_n = '0;
    end else if (step && (idx != IDX_MAX)) begin
      idx_n = idx + 1'b1;
    end
  end

  assign idx_en = clr | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_n;
    end
  end

endmodule

// File: rtl/kpc_param_chk.sv
module kpc_param_chk #(
  parameter int KP_MIN     = 3,
  parameter int KP_COL_MAX = 12,
  parameter int KP_ROW_MAX = 8
) (
  input  logic [7:0] val,
  output logic       size_bad,
  output logic       dbnc_bad,
  output logic       clk_bad,
  output logic       rst_key_ok
);

  import kpc_pkg::*;

  logic [3:0] cols;
  logic [3:0] rows;

  assign cols = val[3:0];
  assign rows = val[7:4];

  always_comb begin
    size_bad = (int'(cols) < KP_MIN) || (int'(cols) > KP_COL_MAX) ||
               (int'(rows) < KP_MIN) || (int'(rows) > KP_ROW_MAX);
    dbnc_bad   = (val == 8'h00);
    clk_bad    = val[0] ^ val[1];
    rst_key_ok = (val == SOFT_RST_KEY);
  end

endmodule

// File: rtl/kpc_wr_dec.sv
module kpc_wr_dec #(
  parameter int IDX_W = 3
) (
  input  logic                    en,
  input  logic [7:0]              cmd,
  input  logic [IDX_W-1:0]        pidx,
  input  logic                    size_bad,
  input  logic                    dbnc_bad,
  input  logic                    clk_bad,
  input  logic                    rst_key_ok,
  output kpc_pkg::wr_act_t        act
);

  import kpc_pkg::*;

  logic [GPIO_REGS-1:0] gsel;

  assign gsel = GPIO_REGS'(1) << cmd[1:0];

  always_comb begin
    act = '0;
    if (en) begin
      case (cmd)
        OP_CFG_WR: begin
          act.cfg_we  = 1'b1;
          act.cfg_clr = 1'b1;
          act.done    = 1'b1;
        end
        OP_SOFT_RST: begin
          act.done     = 1'b1;
          act.soft_rst = rst_key_ok;
          act.bad_par  = !rst_key_ok;
        end
        OP_PULL_WR, OP_DIR_WR, OP_STATE_WR: begin
          if (pidx == '0) begin
            act.gpio_lo_we = gsel;
          end else begin
            act.gpio_hi_we = gsel;
            act.done       = 1'b1;
          end
        end
        OP_ACT_WR: begin
          act.act_we = 1'b1;
          act.done   = 1'b1;
        end
        OP_DBNC_WR: begin
          act.dbnc_we = 1'b1;
          act.done    = 1'b1;
          act.bad_par = dbnc_bad;
        end
        OP_SIZE_WR: begin
          act.size_we = 1'b1;
          act.done    = 1'b1;
          act.bad_par = size_bad;
        end
        OP_CLK_WR: begin
          act.clk_we  = 1'b1;
          act.done    = 1'b1;
          act.bad_par = clk_bad;
        end
        OP_LOCKOUT: begin
          act.bad_par = 1'b1;
        end
        default: begin
          act.unk_cmd = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/kpc_rd_mux.sv
module kpc_rd_mux #(
  parameter int IDX_W = 3
) (
  input  logic [7:0]               cmd,
  input  logic [IDX_W-1:0]         idx,
  input  kpc_pkg::ctl_regs_t       ctl,
  input  logic [7:0]               status,
  input  logic [7:0]               error,
  input  logic [15:0]              dir,
  input  logic [15:0]              state,
  output logic [7:0]               data,
  output logic                     rd_unk,
  output logic                     stat_rd
);

  import kpc_pkg::*;

  logic first_b;
  logic second_b;

  assign first_b  = (idx == '0);
  assign second_b = (idx == IDX_W'(1));

  always_comb begin
    data    = 8'h00;
    rd_unk  = 1'b0;
    stat_rd = 1'b0;
    case (cmd)
      OP_ID_RD: begin
        if (first_b)       data = ID_WORD[7:0];
        else if (second_b) data = ID_WORD[15:8];
      end
      OP_STAT_RD: begin
        stat_rd = 1'b1;
        if (first_b) data = status;
      end
      OP_DIR_RD: begin
        if (first_b)       data = dir[7:0];
        else if (second_b) data = dir[15:8];
      end
      OP_STATE_RD: begin
        if (first_b)       data = state[7:0];
        else if (second_b) data = state[15:8];
      end
      OP_FIFO_POP, OP_FIFO_PEEK, OP_ROT_RD: begin
        data = 8'h00;
      end
      OP_ERR_RD:  data = error;
      OP_SIZE_RD: data = ctl.size;
      OP_CFG_RD:  data = {4'h0, ctl.cfg[3:0]};
      OP_CLK_RD:  data = {ctl.clkc[7:2], 2'b10};
      default: begin
        rd_unk = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/kpc_cmd_ctrl.sv
module kpc_cmd_ctrl #(
  parameter int IDX_W      = 3,
  parameter int KP_MIN     = 3,
  parameter int KP_COL_MAX = 12,
  parameter int KP_ROW_MAX = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txn_start,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        rd_req,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic        key_evt,
  output logic        irq_n,
  output logic        fifo_clr,
  output logic [7:0]  cfg_q,
  output logic [7:0]  act_time,
  output logic [7:0]  dbnc_time,
  output logic [7:0]  kp_size,
  output logic [7:0]  clk_cfg,
  output logic [15:0] gpio_pull,
  output logic [15:0] gpio_dir,
  output logic [15:0] gpio_state
);

  import kpc_pkg::*;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_ni = rst_sync[1];

  // State
  ctl_regs_t                      ctl_q,    ctl_n;
  logic [7:0]                     status_q, status_n;
  logic [7:0]                     error_q,  error_n;
  logic [7:0]                     cmd_q,    cmd_n;
  logic [GPIO_REGS-1:0][GPIO_W-1:0] gpio_q, gpio_n;
  logic [7:0]                     rd_data_q;
  logic                           rd_valid_q;
  logic                           fifo_clr_q;

  // Strobe qualification
  logic [IDX_W-1:0] byte_idx;
  logic [IDX_W-1:0] pidx;
  logic             cmd_en;
  logic             par_en;
  logic             rd_en;
  logic             step;

  assign cmd_en = wr_valid && !txn_start && (byte_idx == '0);
  assign par_en = wr_valid && !txn_start && (byte_idx != '0);
  assign rd_en  = rd_req && !txn_start;
  assign step   = (wr_valid || rd_req) && !txn_start;
  assign pidx   = byte_idx - 1'b1;

  kpc_byte_idx #(.IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (txn_start),
    .step  (step),
    .idx   (byte_idx)
  );

  logic size_bad, dbnc_bad, clk_bad, rst_key_ok;

  kpc_param_chk #(
    .KP_MIN     (KP_MIN),
    .KP_COL_MAX (KP_COL_MAX),
    .KP_ROW_MAX (KP_ROW_MAX)
  ) u_chk_par (
    .val        (wr_data),
    .size_bad   (size_bad),
    .dbnc_bad   (dbnc_bad),
    .clk_bad    (clk_bad),
    .rst_key_ok (rst_key_ok)
  );

  wr_act_t act;

  kpc_wr_dec #(.IDX_W(IDX_W)) u_wr_dec (
    .en         (par_en),
    .cmd        (cmd_q),
    .pidx       (pidx),
    .size_bad   (size_bad),
    .dbnc_bad   (dbnc_bad),
    .clk_bad    (clk_bad),
    .rst_key_ok (rst_key_ok),
    .act        (act)
  );

  logic [7:0] rsp_data;
  logic       rd_unk;
  logic       stat_rd;

  kpc_rd_mux #(.IDX_W(IDX_W)) u_rd_mux (
    .cmd     (cmd_q),
    .idx     (byte_idx),
    .ctl     (ctl_q),
    .status  (status_q),
    .error   (error_q),
    .dir     (gpio_q[GPIO_DIR]),
    .state   (gpio_q[GPIO_ST]),
    .data    (rsp_data),
    .rd_unk  (rd_unk),
    .stat_rd (stat_rd)
  );

  // Next state
  logic [7:0] err_set;

  always_comb begin
    ctl_n    = ctl_q;
    status_n = status_q;
    error_n  = error_q;
    cmd_n    = cmd_q;
    gpio_n   = gpio_q;
    err_set  = 8'h00;

    if (cmd_en) begin
      cmd_n = wr_data;
    end

    if (par_en) begin
      if (act.cfg_we)  ctl_n.cfg  = wr_data;
      if (act.act_we)  ctl_n.act  = wr_data;
      if (act.dbnc_we) ctl_n.dbnc = wr_data;
      if (act.size_we) ctl_n.size = wr_data;
      if (act.clk_we)  ctl_n.clkc = wr_data;
      for (int g = 0; g < GPIO_REGS; g++) begin
        if (act.gpio_lo_we[g]) gpio_n[g] = {8'h00, wr_data};
        if (act.gpio_hi_we[g]) gpio_n[g][GPIO_W-1:8] = wr_data;
      end
      if (act.done) begin
        cmd_n = OP_LOCKOUT;
      end
      if (act.soft_rst) begin
        ctl_n    = CTL_RST;
        status_n = STATUS_RST;
      end
      if (act.cfg_clr) begin
        status_n = 8'h00;
      end
      err_set[ER_BADPAR] = act.bad_par;
      err_set[ER_UNKCMD] = act.unk_cmd;
    end

    if (rd_en) begin
      err_set[ER_UNKCMD] = err_set[ER_UNKCMD] | rd_unk;
      if (stat_rd && !status_q[ST_NOINIT]) begin
        status_n = 8'h00;
      end
    end

    if (err_set != 8'h00) begin
      error_n          = error_n | err_set;
      status_n[ST_ERR] = 1'b1;
    end

    if (key_evt) begin
      status_n[ST_KEY] = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= CTL_RST;
      status_q <= STATUS_RST;
      error_q  <= 8'h00;
      cmd_q    <= OP_LOCKOUT;
      gpio_q   <= '0;
    end else begin
      ctl_q    <= ctl_n;
      status_q <= status_n;
      error_q  <= error_n;
      cmd_q    <= cmd_n;
      gpio_q   <= gpio_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= 8'h00;
    end else if (rd_en) begin
      rd_data_q <= rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      fifo_clr_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      fifo_clr_q <= act.cfg_clr;
    end
  end

  // Outputs
  assign rd_data    = rd_data_q;
  assign rd_valid   = rd_valid_q;
  assign irq_n      = (status_q == 8'h00);
  assign fifo_clr   = fifo_clr_q;
  assign cfg_q      = ctl_q.cfg;
  assign act_time   = ctl_q.act;
  assign dbnc_time  = ctl_q.dbnc;
  assign kp_size    = ctl_q.size;
  assign clk_cfg    = ctl_q.clkc;
  assign gpio_pull  = gpio_q[GPIO_PULL];
  assign gpio_dir   = gpio_q[GPIO_DIR];
  assign gpio_state = gpio_q[GPIO_ST];

endmodule

// File: rtl/kpc_cmd_ctrl_chk.sv
module kpc_cmd_ctrl_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_start,
  input logic             wr_valid,
  input logic [7:0]       wr_data,
  input logic             rd_req,
  input logic [7:0]       cmd_q,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       status_q,
  input logic [7:0]       error_q
);

  // R3: first byte of a write transaction becomes the command code
  a_r3_cmd_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !txn_start && (idx_q == '0)) |=> (cmd_q == $past(wr_data)));

  // R4: a parameter while locked out flags a bad parameter
  a_r4_lockout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !txn_start && (idx_q != '0) && (cmd_q == 8'hFF)) |=> error_q[0]);

  // R5: error bits never drop
  a_r5_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((error_q & $past(error_q)) == $past(error_q)));

  // R5: a changed error byte is reported in status bit 3
  a_r5_error_status: assert property (@(posedge clk) disable iff (!rst_n)
    (error_q != $past(error_q)) |-> status_q[3]);

  // R7: status read leaves the not-initialised bit in place
  a_r7_noinit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_valid && !txn_start && status_q[4]) |=> status_q[4]);

  // R12: configuration write clears every status bit above the key bit
  a_r12_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !txn_start && (idx_q != '0) && (cmd_q == 8'h81)) |=> (status_q[7:1] == 7'h00));

endmodule

bind kpc_cmd_ctrl kpc_cmd_ctrl_chk #(.IDX_W(IDX_W)) u_kpc_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .txn_start (txn_start),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data),
  .rd_req    (rd_req),
  .cmd_q     (cmd_q),
  .idx_q     (byte_idx),
  .status_q  (status_q),
  .error_q   (error_q)
);

// File: tb/tb_kpc_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_kpc_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_start = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        key_evt = 1'b0;
  logic        irq_n;
  logic        fifo_clr;
  logic [7:0]  cfg_q, act_time, dbnc_time, kp_size, clk_cfg;
  logic [15:0] gpio_pull, gpio_dir, gpio_state;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  kpc_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
    .key_evt(key_evt), .irq_n(irq_n), .fifo_clr(fifo_clr), .cfg_q(cfg_q),
    .act_time(act_time), .dbnc_time(dbnc_time), .kp_size(kp_size),
    .clk_cfg(clk_cfg), .gpio_pull(gpio_pull), .gpio_dir(gpio_dir),
    .gpio_state(gpio_state)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // All primitives are entered and left at a falling edge
  task automatic hw_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic st();
    txn_start = 1'b1;
    @(negedge clk);
    txn_start = 1'b0;
  endtask

  task automatic wb(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rb(output logic [7:0] d);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data;
  endtask

  task automatic cmd1(input logic [7:0] op, input logic [7:0] v);
    st(); wb(op); wb(v);
  endtask

  task automatic rd1(input logic [7:0] op, output logic [7:0] d);
    st(); wb(op); st(); rb(d);
  endtask

  task automatic prep();
    hw_reset();
    cmd1(8'h81, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    hw_reset();
    chk("R1 irq_n after reset", irq_n, 0);
    chk("R1 cfg", cfg_q, 16'h80);
    chk("R1 act", act_time, 16'd125);
    chk("R1 dbnc", dbnc_time, 16'd3);
    chk("R1 size", kp_size, 16'h33);
    chk("R1 clk", clk_cfg, 16'h08);
    chk("R1 gpio", {gpio_pull | gpio_dir | gpio_state}, 16'h0);
    rd1(8'h8C, d);
    chk("R1 error byte", d, 16'h00);
    rd1(8'h82, d);
    chk("R7 status while noinit", d, 16'h10);
    rd1(8'h82, d);
    chk("R7 noinit not cleared", d, 16'h10);
    chk("R2 irq_n held low", irq_n, 0);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    hw_reset();
    st(); wb(8'h81); wb(8'hF7);
    chk("R12 fifo_clr pulse", fifo_clr, 1);
    chk("R12 cfg stored", cfg_q, 16'hF7);
    chk("R2 irq_n high when status clear", irq_n, 1);
    @(negedge clk);
    chk("R12 fifo_clr one cycle", fifo_clr, 0);
    st(); wb(8'h92); st();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R11 rd_valid", rd_valid, 1);
    chk("R11 cfg low nibble", rd_data, 16'h07);
  endtask

  task automatic t_lockout();
    logic [7:0] d;
    prep();
    st(); wb(8'h8B); wb(8'h40);
    chk("R3 act param 0", act_time, 16'h40);
    chk("R3 no error yet", irq_n, 1);
    wb(8'h41);
    chk("R4 extra byte ignored", act_time, 16'h40);
    chk("R4 irq on lockout", irq_n, 0);
    rd1(8'h8C, d);
    chk("R4 bad-param bit", d, 16'h01);
    rd1(8'h82, d);
    chk("R5 status bit 3", d, 16'h08);
    chk("R7 irq_n after clear", irq_n, 1);
    rd1(8'h82, d);
    chk("R7 status cleared", d, 16'h00);
    st(); wb(8'h99);
    chk("R3 code alone no error", irq_n, 1);
    wb(8'h12);
    rd1(8'h8C, d);
    chk("R5 unknown OR sticky", d, 16'h03);
  endtask

  task automatic t_unknown_rd();
    logic [7:0] d;
    prep();
    rd1(8'h7F, d);
    chk("R5 unknown read data", d, 16'h00);
    chk("R5 unknown read irq", irq_n, 0);
    rd1(8'h8C, d);
    chk("R5 unknown read error", d, 16'h02);
  endtask

  task automatic size_case(input logic [7:0] v, input logic bad);
    logic [7:0] d;
    rd1(8'h82, d);
    cmd1(8'h90, v);
    chk("R8 size stored", kp_size, {8'h00, v});
    chk("R8 size verdict", irq_n, !bad);
    rd1(8'h91, d);
    chk("R11 size readback", d, {8'h00, v});
  endtask

  task automatic t_size();
    prep();
    size_case(8'h33, 0);
    size_case(8'h8C, 0);
    size_case(8'h2C, 1);
    size_case(8'h93, 1);
    size_case(8'h32, 1);
    size_case(8'h8D, 1);
  endtask

  task automatic val_case(input string req, input logic [7:0] op, input logic [7:0] v,
                          input logic bad);
    logic [7:0] d;
    rd1(8'h82, d);
    cmd1(op, v);
    chk(req, irq_n, !bad);
  endtask

  task automatic t_dbnc_clk();
    logic [7:0] d;
    prep();
    val_case("R9 debounce 0", 8'h8F, 8'h00, 1);
    chk("R9 debounce stored", dbnc_time, 16'h00);
    val_case("R9 debounce 1", 8'h8F, 8'h01, 0);
    val_case("R9 clock 00", 8'h93, 8'h00, 0);
    val_case("R9 clock 11", 8'h93, 8'h03, 0);
    val_case("R9 clock 01", 8'h93, 8'h01, 1);
    val_case("R9 clock 10", 8'h93, 8'hFE, 1);
    val_case("R9 clock 01 high", 8'h93, 8'hF1, 1);
    chk("R9 clock stored", clk_cfg, 16'hF1);
    rd1(8'h94, d);
    chk("R11 clock readback", d, 16'hF2);
  endtask

  task automatic t_gpio();
    logic [7:0] d0, d1, d2;
    prep();
    st(); wb(8'h85); wb(8'h34); wb(8'h12);
    chk("R10 dir", gpio_dir, 16'h1234);
    st(); wb(8'h86); wb(8'hCD); wb(8'hAB);
    chk("R10 state", gpio_state, 16'hABCD);
    st(); wb(8'h84); wb(8'h01); wb(8'h80);
    chk("R10 pull", gpio_pull, 16'h8001);
    chk("R10 no error", irq_n, 1);
    wb(8'h55);
    chk("R4 lockout after high byte", irq_n, 0);
    chk("R4 pull unchanged", gpio_pull, 16'h8001);
    st(); wb(8'h87); st(); rb(d0); rb(d1); rb(d2);
    chk("R10 dir readback", {d1, d0}, 16'h1234);
    chk("R10 dir fill", d2, 16'h00);
    st(); wb(8'h88); st(); rb(d0); rb(d1);
    chk("R10 state readback", {d1, d0}, 16'hABCD);
    st(); wb(8'h85); wb(8'h77); st();
    chk("R10 low byte clears high", gpio_dir, 16'h0077);
  endtask

  task automatic t_id();
    logic [7:0] d0, d1, d2, d3, d4;
    prep();
    st(); wb(8'h80); st(); rb(d0); rb(d1); rb(d2);
    chk("R11 id byte 0", d0, 16'h00);
    chk("R11 id byte 1", d1, 16'h04);
    chk("R11 id byte 2", d2, 16'h00);
    st(); rb(d3); rb(d4);
    chk("R3 start clears index", {d4, d3}, 16'h0400);
  endtask

  task automatic t_softrst();
    logic [7:0] d;
    prep();
    cmd1(8'h8B, 8'h11);
    cmd1(8'h90, 8'h44);
    st(); wb(8'h85); wb(8'h22); wb(8'h11);
    cmd1(8'h83, 8'h55);
    chk("R6 wrong key flags", irq_n, 0);
    chk("R6 wrong key no reset", act_time, 16'h11);
    rd1(8'h82, d);
    chk("R6 wrong key status", d, 16'h08);
    cmd1(8'h83, 8'hAA);
    chk("R6 act restored", act_time, 16'd125);
    chk("R6 size restored", kp_size, 16'h33);
    chk("R6 cfg restored", cfg_q, 16'h80);
    chk("R6 gpio kept", gpio_dir, 16'h1122);
    rd1(8'h82, d);
    chk("R6 status noinit", d, 16'h10);
    rd1(8'h8C, d);
    chk("R6 error kept", d, 16'h01);
  endtask

  task automatic t_key();
    logic [7:0] d;
    prep();
    key_evt = 1'b1;
    @(negedge clk);
    key_evt = 1'b0;
    chk("R13 key raises irq", irq_n, 0);
    rd1(8'h82, d);
    chk("R13 key status bit", d, 16'h01);
    chk("R7 irq_n after clear", irq_n, 1);
    rd1(8'h82, d);
    chk("R7 cleared after read", d, 16'h00);
  endtask

  initial begin
    t_reset();
    t_cfg();
    t_lockout();
    t_unknown_rd();
    t_size();
    t_dbnc_clk();
    t_gpio();
    t_id();
    t_softrst();
    t_key();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule